// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block synchronizes P requesters, such as cores or hardware threads, at a common meeting point. A requester announces that it has reached the meeting point with a one-cycle pulse on its bit of `arrive_i`. It is then held in a waiting state until every one of the P requesters has arrived. When the final arrival is accepted, all requesters are released together. The unit can be used again straight away for the next episode.

The design keeps one shared count of the arrivals still missing and one global phase bit. Each requester also has its own private phase bit. Every accepted arrival inverts that requester's private bit. A requester is waiting whenever its private bit differs from the global bit. The arrival that completes an episode reloads the count and copies its new private value into the global bit. That single flip releases everyone.

Release depends on the phase bits and not on the count returning to full. Because of this, a requester that re-enters the barrier at once after a release cannot disturb peers that have not yet seen the release. Pulses that land in the same cycle are summed, so the count drops by exactly the number of arrivals accepted. All pins are plain control and status lines, and no data stream crosses the block, so there is no valid/ready handshake. An arrive pulse is sampled on every rising clock edge and is never back-pressured.

Top module: `srb_barrier`

## Requirements
- R1: During and after reset, with no arrivals, every bit of `waiting_o` and `released_o` is 0.
- R2: An arrive pulse from a requester that is not waiting is accepted at the clock edge. From the next cycle that requester shows `waiting_o`=1 and `released_o`=0, unless the same acceptance completes the episode.
- R3: An arrive pulse from a requester whose `waiting_o` is 1 is ignored: it does not count toward the episode, and the requester stays waiting.
- R4: No requester is released, and no waiting requester leaves the waiting state, before P distinct arrivals have been accepted in the current episode.
- R5: In the cycle after the edge that accepts the P-th arrival of an episode, every bit of `waiting_o` is 0 and every bit of `released_o` is 1.
- R6: Arrivals from several requesters in one cycle are all accepted and all counted. A single cycle with all P requesters arriving completes an episode at once.
- R7: `released_o` for a requester stays 1 until that requester's next accepted arrival, however many idle cycles pass.
- R8: Episodes can run back to back. A requester that arrives in the first cycle after a release starts the next episode. The other requesters stay released, and the next episode still needs all P arrivals. This holds over consecutive episodes in any arrival order.
- R9: For any requester, `waiting_o` and `released_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | P | One-cycle arrival pulse per requester |
| waiting_o | output | P | Requester has arrived and is blocked |
| released_o | output | P | Requester was released by the last completed episode |

## Verification
The bound checker looks at every cycle and checks the following:
- `waiting_o` and `released_o` are never both 1 for the same requester.
- A waiting requester only ever moves to released.
- Any drop of a waiting bit comes with a full release vector.
- A released flag is held until its owner arrives again.
- An arrival from a released requester leads either to waiting or to a complete release.

Only the bench scenarios can show the counting itself. These include the following:
- Release comes on exactly the P-th distinct arrival.
- Duplicate pulses are not counted.
- Same-cycle arrivals are summed.
- A fast requester re-entering the barrier is credited to the next episode across several shuffled orders.

// File: rtl/srb_pkg.sv
package srb_pkg;
  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/srb_slot.sv
// Per-requester state: private phase bit and release flag.
module srb_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive,
  input  logic gsense,
  input  logic release_pulse,
  output logic accept,
  output logic waiting,
  output logic released,
  output logic lsense_next
);
  logic lsense_q;
  logic rel_q;

  assign waiting     = lsense_q ^ gsense;
  assign accept      = arrive & ~waiting;
  assign lsense_next = lsense_q ^ accept;
  assign released    = rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsense_q <= 1'b1;
      rel_q    <= 1'b0;
    end else begin
      lsense_q <= lsense_next;
      if (release_pulse)
        rel_q <= 1'b1;
      else if (accept)
        rel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/srb_tally.sv
// Shared count of missing arrivals; combined decrement per cycle.
module srb_tally #(
  parameter int unsigned P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] acc_vec,
  output logic         last
);
  import srb_pkg::*;
  localparam int unsigned CW = cnt_bits(P);
  localparam logic [CW-1:0] FULL = CW'(P);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] n_acc;

  always_comb begin
    n_acc = '0;
    for (int i = 0; i < int'(P); i++)
      n_acc = n_acc + CW'(acc_vec[i]);
  end

  assign last = (n_acc != '0) && (n_acc == cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= FULL;
    else if (last)
      cnt_q <= FULL;
    else
      cnt_q <= cnt_q - n_acc;
  end
endmodule

// File: rtl/srb_sense.sv
// Global phase bit; takes the completing requester's new private phase.
module srb_sense #(
  parameter int unsigned P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         last,
  input  logic [P-1:0] acc_vec,
  input  logic [P-1:0] next_vec,
  output logic         gsense
);
  logic gsense_q;
  logic lead;

  always_comb begin
    lead = gsense_q;
    for (int i = int'(P) - 1; i >= 0; i--)
      if (acc_vec[i]) lead = next_vec[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gsense_q <= 1'b1;
    else if (last)
      gsense_q <= lead;
  end

  assign gsense = gsense_q;
endmodule

// File: rtl/srb_barrier.sv
module srb_barrier #(
  parameter int unsigned P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] arrive_i,
  output logic [P-1:0] waiting_o,
  output logic [P-1:0] released_o
);
  logic [P-1:0] acc_vec;
  logic [P-1:0] next_vec;
  logic         last;
  logic         gsense;

  for (genvar g = 0; g < int'(P); g++) begin : g_slot
    srb_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .arrive       (arrive_i[g]),
      .gsense       (gsense),
      .release_pulse(last),
      .accept       (acc_vec[g]),
      .waiting      (waiting_o[g]),
      .released     (released_o[g]),
      .lsense_next  (next_vec[g])
    );
  end

  srb_tally #(.P(P)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_vec(acc_vec),
    .last   (last)
  );

  srb_sense #(.P(P)) u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .last    (last),
    .acc_vec (acc_vec),
    .next_vec(next_vec),
    .gsense  (gsense)
  );
endmodule

// File: rtl/srb_barrier_chk.sv
module srb_barrier_chk #(
  parameter int unsigned P = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [P-1:0] arrive_i,
  input logic [P-1:0] waiting_o,
  input logic [P-1:0] released_o
);
  localparam logic [P-1:0] ALL = '1;

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_o & released_o) == '0);

  p_all_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (($past(waiting_o) & ~waiting_o) != '0)) |-> (released_o == ALL));

  for (genvar g = 0; g < int'(P); g++) begin : g_req
    p_wait_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      waiting_o[g] |=> (waiting_o[g] || released_o[g]));

    p_rel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (released_o[g] && !arrive_i[g]) |=> released_o[g]);

    p_arrive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (released_o[g] && arrive_i[g]) |=> (waiting_o[g] || released_o == ALL));
  end
endmodule

bind srb_barrier srb_barrier_chk #(.P(P)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arrive_i  (arrive_i),
  .waiting_o (waiting_o),
  .released_o(released_o)
);

// File: tb/srb_barrier_tb_top.sv
module srb_barrier_tb_top;
  localparam int unsigned P = 4;
  localparam logic [P-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [P-1:0] arrive_i;
  logic [P-1:0] waiting_o;
  logic [P-1:0] released_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [P-1:0] ewait;
  logic [P-1:0] erel;
  int           epend;

  always #4 clk = ~clk;

  srb_barrier #(.P(P)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive_i),
    .waiting_o (waiting_o),
    .released_o(released_o)
  );

  task automatic check(input string tag);
    checks++;
    if (waiting_o !== ewait || released_o !== erel) begin
      errors++;
      $display("FAIL %s: waiting=%b released=%b expected waiting=%b released=%b",
               tag, waiting_o, released_o, ewait, erel);
    end
  endtask

  task automatic check_excl();
    checks++;
    if ((waiting_o & released_o) != '0) begin
      errors++;
      $display("FAIL R9: overlap=%b expected %b", waiting_o & released_o, {P{1'b0}});
    end
  endtask

  // Drive one cycle of pulses, update the requirement-level model, then check.
  task automatic step(input logic [P-1:0] mask, input string tag);
    logic [P-1:0] acc;
    int n;
    @(negedge clk);
    arrive_i = mask;
    @(negedge clk);
    arrive_i = '0;
    acc = mask & ~ewait;
    n = $countones(acc);
    if (n != 0 && epend + n == int'(P)) begin
      ewait = '0;
      erel  = ALL;
      epend = 0;
    end else begin
      ewait = ewait | acc;
      erel  = erel & ~acc;
      epend = epend + n;
    end
    check(tag);
    check_excl();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    arrive_i = '0;
    ewait = '0; erel = '0; epend = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
  endtask

  task automatic t_in_order();
    for (int i = 0; i < int'(P) - 1; i++)
      step(P'(1) << i, "R2 R4");
    step(P'(1) << (P - 1), "R5");
  endtask

  task automatic t_duplicate();
    step(4'b0001, "R2");
    step(4'b0001, "R3");
    step(4'b0011, "R3");
    step(4'b0100, "R4");
    step(4'b0001, "R3");
    step(4'b1000, "R5");
  endtask

  task automatic t_simultaneous();
    step(4'b0000, "R7");
    step(4'b0110, "R6");
    step(4'b1001, "R6");
    step(ALL, "R6");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 5; k++)
      step(4'b0000, "R7");
    step(4'b0100, "R7");
    step(4'b0000, "R7");
    step(4'b1011, "R5");
  endtask

  task automatic t_back_to_back();
    int ord[P];
    for (int e = 0; e < 4; e++) begin
      for (int i = 0; i < int'(P); i++) ord[i] = i;
      for (int i = int'(P) - 1; i > 0; i--) begin
        int j = $urandom_range(i, 0);
        int t = ord[i]; ord[i] = ord[j]; ord[j] = t;
      end
      for (int i = 0; i < int'(P); i++)
        step(P'(1) << ord[i], (i == 0) ? "R8" : "R8 R4");
    end
  endtask

  initial begin
    void'($urandom(570));
    t_reset();
    t_in_order();
    t_duplicate();
    t_simultaneous();
    t_hold();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule